// File: doc/BRIEF.md
# Triplicated Data-Valid Alignment Delay

This block holds back a data-valid strobe for a fixed number of clock cycles. The strobe frames one triggered event and stays high for that event's whole payload. The sample words for the event come through an external digitizer path and arrive later than the strobe, so the delay brings the two back into line. With the default depth of eight stages, the strobe is delayed by eight cycles, which is 200 ns at a 25 ns clock. The depth must be exact: a line that is one stage short puts every frame out of place.

The delay state is stored in three independent copies. Each stage reads a bitwise majority of the three copies, and that voted value is written back into all three copies on the next shift. A single upset copy is therefore outvoted at once and repaired one clock later. A flag goes high in any cycle where the copies disagree, and a saturating counter records how many such cycles have occurred. The voted, delayed strobe produces a start pulse on its rising edge and an end pulse on its falling edge. These pulses assume that at least one idle cycle separates events. The sample word goes through one register stage.

An upset-injection port lets a test write single-copy flips into the delay state through the normal clocked path.

Top module: `dv_align_tmr`

## Requirements
- R1: While rst_n is low at a clock edge, every stage of all three copies, the error counter, the edge history and the sample register are cleared. After that edge, dv_out, sof, eof, err_flag, err_count and sample_out are all zero.
- R2: dv_out equals the value that dv_in had DEPTH clock edges earlier, counted from the edge that captured it. The default DEPTH is 8.
- R3: sample_out equals the sample_in value that was captured at the previous clock edge. It therefore changes on the same edge as dv_out.
- R4: Flipping any set of bits in a single copy, selected by seu_lane values 0, 1 or 2 with seu_flip bit i addressing stage i, never changes dv_out, sof or eof.
- R5: After an edge at which a nonzero seu_flip was applied to lane 0, 1 or 2, err_flag is high for that cycle. It is low after the next edge if no injection is applied at that edge.
- R6: err_count increases by one at each clock edge where err_flag was high before the edge, and holds at 255 once it reaches that value. It does not change at any other edge.
- R7: sof is high for exactly the cycle in which dv_out has just gone from 0 to 1.
- R8: eof is high for exactly the cycle in which dv_out has just gone from 1 to 0.
- R9: seu_lane value 3 disables injection. With that value, a nonzero seu_flip leaves err_flag low after the edge and leaves dv_out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one sample word per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| dv_in | input | 1 | Raw data-valid strobe |
| sample_in | input | SAMPLE_W (8) | Digitized sample word |
| seu_lane | input | 2 | Copy selected for upset injection; 3 means none |
| seu_flip | input | DEPTH (8) | Per-stage flip mask applied to the selected copy |
| dv_out | output | 1 | Voted, delayed data-valid |
| sample_out | output | SAMPLE_W (8) | Sample word after one register stage |
| sof | output | 1 | Start-of-event pulse |
| eof | output | 1 | End-of-event pulse |
| err_flag | output | 1 | High while the three copies disagree |
| err_count | output | CNT_W (8) | Saturating count of disagreement cycles |

## Verification
The assertions assume that only one copy is corrupted at a time, which is why injection is restricted to a single lane per edge. They also assume that events on dv_in are separated by at least one low cycle. The random stimulus builds events of one to twelve cycles of high strobe, always followed by an idle gap of one to five cycles. At random edges it applies arbitrary flip masks to one randomly chosen lane, including the disabled lane value 3. A directed phase injects on every edge for long enough to drive the counter into saturation, and a reset in the middle of the run checks that all state clears.

// File: rtl/dv_align_pkg.sv
// Package: shared constants for the data-valid alignment delay.
// Assumes: three redundant copies; lane code 3 means "no injection".
package dv_align_pkg;
    localparam int unsigned N_COPIES = 3;
    localparam logic [1:0]  LANE_OFF = 2'd3;
endpackage

// File: rtl/tmr_delay_line.sv
// Module: triplicated shift register with per-stage majority vote.
// Each stage of every copy loads the voted value of the stage before it,
// so a single-copy upset is corrected at the next edge. An optional flip
// mask is XORed into one selected copy for upset testing.
// Assumes: DEPTH >= 2; at most one copy is corrupt at any time.
module tmr_delay_line
    import dv_align_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic [1:0]       inj_lane,
    input  logic [DEPTH-1:0] inj_mask,
    output logic [DEPTH-1:0] voted,
    output logic             disagree
);
    logic [DEPTH-1:0] shifted;
    logic [DEPTH-1:0] cq [N_COPIES];

    // Next contents: voted state moved one stage on, new bit at stage 0.
    assign shifted = {voted[DEPTH-2:0], bit_in};

    for (genvar c = 0; c < N_COPIES; c++) begin : g_copy
        logic [DEPTH-1:0] q;
        logic             hit;
        assign hit = (inj_lane == 2'(c));
        // One redundant copy: clear on reset, else load voted shift (plus any injected flips).
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= shifted ^ (hit ? inj_mask : '0);
        end
        assign cq[c] = q;
    end

    // Bitwise two-of-three vote across the copies.
    always_comb voted = (cq[0] & cq[1]) | (cq[1] & cq[2]) | (cq[0] & cq[2]);

    // Any stage where a copy disagrees with another.
    always_comb disagree = |((cq[0] ^ cq[1]) | (cq[1] ^ cq[2]));
endmodule

// File: rtl/edge_marker.sv
// Module: start/end pulse generator on a framing strobe.
// Assumes: strobe has at least one low cycle between events, so start and
// end never fall in the same cycle.
module edge_marker (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise,
    output logic fall
);
    logic prev_q;

    // Remember the strobe level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= strobe;
    end

    // Edge decode against the remembered level.
    always_comb begin
        rise = strobe & ~prev_q;
        fall = ~strobe & prev_q;
    end
endmodule

// File: rtl/sat_counter.sv
// Module: saturating event counter.
// Increments once per clock while inc is high, stops at all-ones.
module sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    // Count up on each flagged cycle until the ceiling is reached.
    always_ff @(posedge clk) begin
        if (!rst_n)                 count <= '0;
        else if (inc && count != TOP) count <= count + 1'b1;
    end
endmodule

// File: rtl/dv_align_tmr.sv
// Module: top of the data-valid alignment delay.
// Delays dv_in by DEPTH cycles through a triplicated, voted line; registers
// the sample word once so both leave together; marks event start and end;
// flags and counts disagreement between the copies.
// Assumes: events on dv_in are separated by at least one idle cycle.
module dv_align_tmr
    import dv_align_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int SAMPLE_W = 8,
    parameter int CNT_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dv_in,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic [1:0]          seu_lane,
    input  logic [DEPTH-1:0]    seu_flip,
    output logic                dv_out,
    output logic [SAMPLE_W-1:0] sample_out,
    output logic                sof,
    output logic                eof,
    output logic                err_flag,
    output logic [CNT_W-1:0]    err_count
);
    logic [DEPTH-1:0] vote;

    tmr_delay_line #(.DEPTH(DEPTH)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_in   (dv_in),
        .inj_lane (seu_lane),
        .inj_mask (seu_flip),
        .voted    (vote),
        .disagree (err_flag)
    );

    assign dv_out = vote[DEPTH-1];

    edge_marker u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (dv_out),
        .rise   (sof),
        .fall   (eof)
    );

    sat_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (err_flag),
        .count (err_count)
    );

    // Single register stage on the sample word.
    always_ff @(posedge clk) begin
        if (!rst_n) sample_out <= '0;
        else        sample_out <= sample_in;
    end
endmodule

// File: rtl/dv_align_tmr_chk.sv
// Module: assertion checker bound to dv_align_tmr.
// Assumes: injections target one lane per edge.
module dv_align_tmr_chk #(
    parameter int DEPTH    = 8,
    parameter int SAMPLE_W = 8,
    parameter int CNT_W    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                dv_in,
    input logic [SAMPLE_W-1:0] sample_in,
    input logic [1:0]          seu_lane,
    input logic [DEPTH-1:0]    seu_flip,
    input logic [DEPTH-1:0]    vote,
    input logic                dv_out,
    input logic [SAMPLE_W-1:0] sample_out,
    input logic                sof,
    input logic                eof,
    input logic                err_flag,
    input logic [CNT_W-1:0]    err_count
);
    localparam logic [CNT_W-1:0] TOP = '1;
    logic armed;

    // Goes high one cycle after reset is released, so $past never sees pre-reset values.
    always_ff @(posedge clk) armed <= rst_n;

    // R2: stage 0 takes the input, each later stage takes the previous stage.
    a_r2_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> vote[0] == $past(dv_in));
    for (genvar i = 1; i < DEPTH; i++) begin : g_shift
        a_r2_stage_shift: assert property (@(posedge clk) disable iff (!rst_n)
            armed |-> vote[i] == $past(vote[i-1]));
    end

    // R3: the sample leaves one edge after it is captured.
    a_r3_sample_pipe: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> sample_out == $past(sample_in));

    // R5: an injection into one lane raises the flag after the edge.
    a_r5_inject_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (seu_lane != 2'd3 && seu_flip != '0) |=> err_flag);

    // R9 / R5: without injection at an edge, the copies agree after it.
    a_r9_no_inject_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (seu_lane == 2'd3 || seu_flip == '0) |=> !err_flag);

    // R6: counter steps on flagged cycles, holds otherwise and at the top.
    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && err_count != TOP) |=> err_count == $past(err_count) + 1'b1);
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_flag || err_count == TOP) |=> $stable(err_count));

    // R7 / R8: pulses match the level of dv_out and are mutually exclusive.
    a_r7_sof_level: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> dv_out);
    a_r8_eof_level: assert property (@(posedge clk) disable iff (!rst_n)
        eof |-> !dv_out);
    a_r7_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sof, eof}));
endmodule

bind dv_align_tmr dv_align_tmr_chk #(
    .DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .dv_in(dv_in), .sample_in(sample_in),
    .seu_lane(seu_lane), .seu_flip(seu_flip), .vote(vote),
    .dv_out(dv_out), .sample_out(sample_out), .sof(sof), .eof(eof),
    .err_flag(err_flag), .err_count(err_count)
);

// File: tb/dv_align_tmr_bench.sv
// Bench: random events with idle gaps, random single-lane upsets, directed
// reset, short-event and saturation phases. Expected values come from a
// delay model built from the requirements.
module dv_align_tmr_bench;
    localparam int DEPTH = 8;
    localparam int SW    = 8;
    localparam int CW    = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          dv_in;
    logic [SW-1:0] sample_in;
    logic [1:0]    seu_lane;
    logic [DEPTH-1:0] seu_flip;
    logic          dv_out, sof, eof, err_flag;
    logic [SW-1:0] sample_out;
    logic [CW-1:0] err_count;

    int checks = 0;
    int fails  = 0;

    // Reference state
    logic [DEPTH-1:0] m_sr;
    logic             m_prev;
    logic             m_flag;
    int               m_cnt;
    logic [SW-1:0]    m_smp;

    always #4 clk = ~clk;

    dv_align_tmr #(.DEPTH(DEPTH), .SAMPLE_W(SW), .CNT_W(CW)) u_dv_align_tmr (
        .clk(clk), .rst_n(rst_n), .dv_in(dv_in), .sample_in(sample_in),
        .seu_lane(seu_lane), .seu_flip(seu_flip), .dv_out(dv_out),
        .sample_out(sample_out), .sof(sof), .eof(eof),
        .err_flag(err_flag), .err_count(err_count)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; dv_in = 1'b0; sample_in = '0; seu_lane = 2'd3; seu_flip = '0;
        repeat (2) @(posedge clk);
        #1;
        m_sr = '0; m_prev = 1'b0; m_flag = 1'b0; m_cnt = 0; m_smp = '0;
        chk("R1 dv_out", int'(dv_out), 0);
        chk("R1 sof/eof", int'({sof, eof}), 0);
        chk("R1 err_flag", int'(err_flag), 0);
        chk("R1 err_count", int'(err_count), 0);
        chk("R1 sample_out", int'(sample_out), 0);
        rst_n = 1'b1;
    endtask

    // One clock: apply inputs, advance the model, check just after the edge.
    task automatic step(input logic dv, input logic [SW-1:0] smp,
                        input logic [1:0] lane, input logic [DEPTH-1:0] flip);
        logic exp_dv;
        logic inj;
        dv_in = dv; sample_in = smp; seu_lane = lane; seu_flip = flip;
        @(posedge clk);
        if (m_flag && m_cnt != 255) m_cnt++;
        inj    = (lane != 2'd3) && (flip != '0);
        m_flag = inj;
        m_prev = m_sr[DEPTH-1];
        m_sr   = {m_sr[DEPTH-2:0], dv};
        m_smp  = smp;
        exp_dv = m_sr[DEPTH-1];
        #1;
        chk(inj ? "R4 dv_out under upset" : (lane == 2'd3 && flip != '0) ? "R9 dv_out" : "R2 dv_out",
            int'(dv_out), int'(exp_dv));
        chk("R7 sof", int'(sof), int'(exp_dv & ~m_prev));
        chk("R8 eof", int'(eof), int'(~exp_dv & m_prev));
        chk("R3 sample_out", int'(sample_out), int'(m_smp));
        chk((lane == 2'd3 && flip != '0) ? "R9 err_flag" : "R5 err_flag",
            int'(err_flag), int'(m_flag));
        chk("R6 err_count", int'(err_count), m_cnt);
        sample_in = 'x;
    endtask

    function automatic logic [1:0] pick_lane();
        return (($urandom % 4) == 0) ? 2'($urandom % 4) : 2'd3;
    endfunction

    task automatic rand_event();
        int len = 1 + int'($urandom % 12);
        int gap = 1 + int'($urandom % 5);
        for (int k = 0; k < len; k++) step(1'b1, SW'($urandom), pick_lane(), DEPTH'($urandom));
        for (int k = 0; k < gap; k++) step(1'b0, SW'($urandom), pick_lane(), DEPTH'($urandom));
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        do_reset();
        // R2: single-cycle event, exact 8-cycle alignment, no upsets
        step(1'b1, 8'hA5, 2'd3, '0);
        for (int k = 0; k < DEPTH + 3; k++) step(1'b0, 8'(k), 2'd3, '0);
        // R4: upset every stage of one lane while a long event passes through
        for (int k = 0; k < 10; k++) step(1'b1, 8'h3C, 2'(k % 3), '1);
        for (int k = 0; k < DEPTH + 2; k++) step(1'b0, 8'h00, 2'd3, '0);
        // R9: lane 3 with full mask is ignored
        for (int k = 0; k < 4; k++) step(1'b1, 8'h11, 2'd3, '1);
        for (int k = 0; k < DEPTH + 2; k++) step(1'b0, 8'h22, 2'd3, '0);
        // Random events with random single-lane upsets
        for (int e = 0; e < 250; e++) rand_event();
        // R6: saturate the counter
        for (int k = 0; k < 300; k++) step(k[2], 8'(k), 2'(k % 3), DEPTH'(1 + k));
        for (int k = 0; k < DEPTH + 2; k++) step(1'b0, 8'h00, 2'd3, '0);
        // R1: reset mid-run clears the counter and the line
        step(1'b1, 8'h77, 2'd0, 8'h01);
        do_reset();
        for (int k = 0; k < DEPTH + 2; k++) step(1'b0, 8'h5A, 2'd3, '0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule